// File: doc/BRIEF.md
# Bitstream Ones-Count Decimation Filter

This block turns the one-bit pulse stream of an oversampling delta-sigma modulator into parallel conversion words. It counts how many accepted modulator samples are high over a window of 2^N−1 samples. It presents that count as an N-bit unsigned code, then starts a fresh window with the very next accepted sample. Because a window of 2^N−1 samples can hold anywhere from zero to 2^N−1 ones, the count fills an N-bit code exactly.

The resolution N is chosen at run time from 3 to 12 bits. A larger N gives finer steps at a lower word rate, because the word rate is the sample rate divided by the window length. The block also supplies a two's-complement form of each code with mid-scale mapped to zero. For a ±FS input range, code k then corresponds to −FS + k·2FS/2^N. Samples only enter the window on cycles where their valid strobe is high.

Top module: `bitstream_ones_decimator`

## Requirements
- R1: Each output word in `code_out` equals the number of accepted samples with `bit_in` = 1 in the window that just closed.
- R2: A window holds exactly 2^N−1 accepted samples, where N is the effective resolution. For example, N=3 gives 7 samples, N=4 gives 15 and N=12 gives 4095.
- R3: The effective resolution is `res_sel` limited to the range 3 to 12. A value below 3 acts as 3 and a value above 12 acts as 12.
- R4: `res_sel` is sampled only on the cycle that the first accepted sample of a window is taken. A change later in that window has no effect until the following window.
- R5: A cycle with `bit_valid` low is ignored: it adds nothing to the count and does not advance the window, whatever `bit_in` is.
- R6: The last sample of a window is included in that window's word. `word_valid` is high for exactly one cycle, starting right after the clock edge that took that sample. The next accepted sample is the first sample of the next window.
- R7: `code_signed` equals the code minus 2^(N−1), as a 12-bit two's-complement value, for the N of that window. A 7-sample window with four ones gives code 4 and signed 0. A 15-sample window with nine ones gives code 9 and signed +1.
- R8: `code_out` and `code_signed` hold their values between words. Bits of `code_out` at positions N and above are zero.
- R9: Synchronous reset clears the window, the count, both outputs and `word_valid`. After reset is released, the first word comes out only after a full window of accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Modulator output bit |
| bit_valid | input | 1 | High when `bit_in` carries a sample |
| res_sel | input | 4 | Requested resolution N (limited to 3 to 12) |
| code_out | output | 12 | Unsigned ones count of the last window |
| code_signed | output | 12 | Code minus 2^(N−1), two's complement |
| word_valid | output | 1 | One-cycle pulse when a new word is presented |

## Verification
The bench targets the window boundary. A design that dropped the closing sample, or lost the first sample of the next window, would return codes one count low, or windows one sample long, in back-to-back all-ones runs. It changes `res_sel` in the middle of a window and sends out-of-range selections. A design that applied the new width at once would close the window early or late, and a missing limit would produce the wrong window length. It inserts invalid cycles carrying ones, which would inflate the code if they were counted. It also resets in the middle of a window, where stale partial counts would leak into the first word, and it drives full-scale windows at N=12, where a width slip would wrap the code or the signed value.

// File: rtl/dsdec_pkg.sv
package dsdec_pkg;

   // Smallest resolution the window logic can serve (window of 2^N-1 >= 3)
   localparam int unsigned DSDEC_FLOOR_BITS = 2;

   // Limit a requested resolution to the legal span
   function automatic int unsigned dsdec_limit(input int unsigned req,
                                               input int unsigned lo,
                                               input int unsigned hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction

endpackage

// File: rtl/dsdec_res_ctrl.sv
module dsdec_res_ctrl #(
   parameter int MIN_BITS = 3,
   parameter int MAX_BITS = 12,
   parameter int SEL_W    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] res_sel,
   input  logic             win_open,
   input  logic             take,
   output logic [SEL_W-1:0] eff_n
);

   localparam logic [SEL_W-1:0] LO_N = SEL_W'(MIN_BITS);
   localparam logic [SEL_W-1:0] HI_N = SEL_W'(MAX_BITS);

   logic [SEL_W-1:0] limited;
   logic [SEL_W-1:0] cur_n;

   always_comb begin
      if (res_sel < LO_N)
         limited = LO_N;
      else if (res_sel > HI_N)
         limited = HI_N;
      else
         limited = res_sel;
   end

   // The width of a window is fixed by the request present at its first sample
   always_comb eff_n = win_open ? limited : cur_n;

   always_ff @(posedge clk) begin
      if (rst)
         cur_n <= LO_N;
      else if (take && win_open)
         cur_n <= limited;
   end

   // R3
   res_range_chk: assert property (@(posedge clk) disable iff (rst)
      (eff_n >= LO_N) && (eff_n <= HI_N));

   // R4
   res_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !win_open |=> $stable(cur_n));

endmodule

// File: rtl/dsdec_win_ctr.sv
module dsdec_win_ctr #(
   parameter int CNT_W = 12,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic [SEL_W-1:0] eff_n,
   output logic [CNT_W-1:0] cnt,
   output logic             win_open,
   output logic             last
);

   logic [CNT_W-1:0] span_mask;
   logic [CNT_W-1:0] final_idx;

   // span_mask = 2^N - 1 (window length); final index is one less
   always_comb begin
      span_mask = ~({CNT_W{1'b1}} << eff_n);
      final_idx = span_mask - CNT_W'(1);
   end

   always_comb begin
      win_open = (cnt == '0);
      last     = take && (cnt == final_idx);
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (last)
         cnt <= '0;
      else if (take)
         cnt <= cnt + CNT_W'(1);
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= final_idx);

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(cnt));

endmodule

// File: rtl/dsdec_accum.sv
module dsdec_accum #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic             bit_in,
   input  logic             last,
   output logic [CNT_W-1:0] total
);

   logic [CNT_W-1:0] acc;

   // Running count including the sample offered this cycle
   always_comb total = acc + CNT_W'(take & bit_in);

   always_ff @(posedge clk) begin
      if (rst)
         acc <= '0;
      else if (last)
         acc <= '0;
      else if (take)
         acc <= total;
   end

   // R5
   acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(acc));

endmodule

// File: rtl/dsdec_out_stage.sv
module dsdec_out_stage #(
   parameter int CNT_W = 12,
   parameter int SEL_W = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    last,
   input  logic [CNT_W-1:0]        total,
   input  logic [SEL_W-1:0]        eff_n,
   output logic [CNT_W-1:0]        code_out,
   output logic signed [CNT_W-1:0] code_signed,
   output logic                    word_valid
);

   logic [CNT_W-1:0] mid_scale;
   logic [CNT_W-1:0] offset_val;

   always_comb begin
      mid_scale  = CNT_W'(1) << (eff_n - SEL_W'(1));
      offset_val = total - mid_scale;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         code_out    <= '0;
         code_signed <= '0;
         word_valid  <= 1'b0;
      end else begin
         word_valid <= last;
         if (last) begin
            code_out    <= total;
            code_signed <= $signed(offset_val);
         end
      end
   end

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> !word_valid);

   // R8
   code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !last |=> ($stable(code_out) && $stable(code_signed)));

endmodule

// File: rtl/bitstream_ones_decimator.sv
module bitstream_ones_decimator #(
   parameter int MIN_BITS = 3,
   parameter int MAX_BITS = 12
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bit_in,
   input  logic                       bit_valid,
   input  logic [$clog2(MAX_BITS+1)-1:0] res_sel,
   output logic [MAX_BITS-1:0]        code_out,
   output logic signed [MAX_BITS-1:0] code_signed,
   output logic                       word_valid
);
   import dsdec_pkg::*;

   localparam int SEL_W = $clog2(MAX_BITS + 1);
   localparam int CNT_W = MAX_BITS;

   generate
      if (MIN_BITS < int'(DSDEC_FLOOR_BITS)) begin : g_bad_min
         $error("MIN_BITS below supported floor");
      end
      if (MAX_BITS < MIN_BITS) begin : g_bad_span
         $error("MAX_BITS must not be below MIN_BITS");
      end
      if (MAX_BITS > 24) begin : g_bad_max
         $error("MAX_BITS above 24 is not supported");
      end
   endgenerate

   logic [SEL_W-1:0] eff_n;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] total;
   logic             win_open;
   logic             last;

   dsdec_res_ctrl #(
      .MIN_BITS (MIN_BITS),
      .MAX_BITS (MAX_BITS),
      .SEL_W    (SEL_W)
   ) i_res_ctrl (
      .clk      (clk),
      .rst      (rst),
      .res_sel  (res_sel),
      .win_open (win_open),
      .take     (bit_valid),
      .eff_n    (eff_n)
   );

   dsdec_win_ctr #(
      .CNT_W (CNT_W),
      .SEL_W (SEL_W)
   ) i_win_ctr (
      .clk      (clk),
      .rst      (rst),
      .take     (bit_valid),
      .eff_n    (eff_n),
      .cnt      (cnt),
      .win_open (win_open),
      .last     (last)
   );

   dsdec_accum #(
      .CNT_W (CNT_W)
   ) i_accum (
      .clk    (clk),
      .rst    (rst),
      .take   (bit_valid),
      .bit_in (bit_in),
      .last   (last),
      .total  (total)
   );

   dsdec_out_stage #(
      .CNT_W (CNT_W),
      .SEL_W (SEL_W)
   ) i_out_stage (
      .clk         (clk),
      .rst         (rst),
      .last        (last),
      .total       (total),
      .eff_n       (eff_n),
      .code_out    (code_out),
      .code_signed (code_signed),
      .word_valid  (word_valid)
   );

   // R1
   ones_bound_chk: assert property (@(posedge clk) disable iff (rst)
      total <= cnt + CNT_W'(1));

   // R6
   word_after_take_chk: assert property (@(posedge clk) disable iff (rst)
      word_valid |-> $past(bit_valid));

endmodule

// File: tb/test_bitstream_ones_decimator.sv
module test_bitstream_ones_decimator;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bit_in = 1'b0;
   logic        bit_valid = 1'b0;
   logic [3:0]  res_sel = 4'd3;
   logic [11:0] code_out;
   logic signed [11:0] code_signed;
   logic        word_valid;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   // reference model state
   int m_cnt = 0;
   int m_acc = 0;
   int m_n   = 3;
   int e_code = 0;
   int e_sgn  = 0;
   int e_vld  = 0;

   always #5 clk = ~clk;

   bitstream_ones_decimator i_bitstream_ones_decimator (
      .clk         (clk),
      .rst         (rst),
      .bit_in      (bit_in),
      .bit_valid   (bit_valid),
      .res_sel     (res_sel),
      .code_out    (code_out),
      .code_signed (code_signed),
      .word_valid  (word_valid)
   );

   function automatic int lim_n(input int s);
      if (s < 3) return 3;
      if (s > 12) return 12;
      return s;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_edge();
      if (rst) begin
         m_cnt = 0; m_acc = 0; e_code = 0; e_sgn = 0; e_vld = 0;
      end else if (bit_valid) begin
         if (m_cnt == 0) m_n = lim_n(int'(res_sel));
         m_acc += int'(bit_in);
         m_cnt++;
         if (m_cnt == (1 << m_n) - 1) begin
            e_code = m_acc;
            e_sgn  = m_acc - (1 << (m_n - 1));
            e_vld  = 1;
            m_cnt  = 0;
            m_acc  = 0;
         end else begin
            e_vld = 0;
         end
      end else begin
         e_vld = 0;
      end
   endtask

   task automatic step(input logic b, input logic v, input logic [3:0] s, input string tag);
      bit_in = b; bit_valid = v; res_sel = s;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(tag, "word_valid", int'(word_valid), e_vld);
      chk(tag, "code_out", int'(code_out), e_code);
      chk(tag, "code_signed", int'(code_signed), e_sgn);
   endtask

   task automatic run_const(input int n, input logic b, input logic [3:0] s, input string tag);
      for (int i = 0; i < n; i++) step(b, 1'b1, s, tag);
   endtask

   initial begin
      @(negedge clk);
      // R9: reset state
      rst = 1'b1;
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 4'd3, "R9");
      rst = 1'b0;

      // R1 / R7: 7-sample window with four ones
      begin
         logic [6:0] p7 = 7'b0101101;
         for (int i = 0; i < 7; i++) step(p7[i], 1'b1, 4'd3, "R1");
         chk("R7", "code_out lit", int'(code_out), 4);
         chk("R7", "code_signed lit", int'(code_signed), 0);
      end

      // R2 / R7: 15-sample window with nine ones
      begin
         logic [14:0] p15 = 15'b011010110101101;
         for (int i = 0; i < 15; i++) step(p15[i], 1'b1, 4'd4, "R2");
         chk("R7", "code_out lit", int'(code_out), 9);
         chk("R7", "code_signed lit", int'(code_signed), 1);
      end

      // R6: back-to-back windows, all zeros then all ones
      run_const(7, 1'b0, 4'd3, "R6");
      chk("R6", "zero code", int'(code_signed), -4);
      run_const(14, 1'b1, 4'd3, "R6");
      chk("R6", "full code", int'(code_out), 7);

      // R5: invalid cycles carrying ones between samples
      for (int i = 0; i < 7; i++) begin
         step(1'b1, 1'b0, 4'd3, "R5");
         step(1'b0, 1'b1, 4'd3, "R5");
         step(1'b1, 1'b0, 4'd9, "R5");
      end
      chk("R5", "ignored ones", int'(code_out), 0);

      // R4: change of selection mid-window
      step(1'b1, 1'b1, 4'd3, "R4");
      step(1'b1, 1'b1, 4'd3, "R4");
      run_const(5, 1'b1, 4'd5, "R4");
      chk("R4", "old width kept", int'(code_out), 7);
      run_const(31, 1'b1, 4'd5, "R4");
      chk("R4", "new width", int'(code_out), 31);

      // R3: out-of-range selections
      run_const(7, 1'b1, 4'd0, "R3");
      chk("R3", "low clamp", int'(code_out), 7);
      run_const(4095, 1'b1, 4'd15, "R3");
      chk("R3", "high clamp code", int'(code_out), 4095);
      chk("R8", "high clamp signed", int'(code_signed), 2047);

      // R8: hold between words with idle input
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 4'd3, "R8");

      // R9: reset in the middle of a window
      run_const(3, 1'b1, 4'd3, "R9");
      rst = 1'b1;
      step(1'b1, 1'b1, 4'd3, "R9");
      rst = 1'b0;
      run_const(7, 1'b1, 4'd3, "R9");
      chk("R9", "first word after reset", int'(code_out), 7);

      // constrained random mix
      begin
         logic [3:0] s = 4'd4;
         void'($urandom(32'd7719));
         for (int i = 0; i < 6000; i++) begin
            if (($urandom % 150) == 0) s = 4'($urandom % 8);
            step(1'($urandom % 2), ($urandom % 4) != 0, s, "R1");
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

endmodule